// File: doc/BRIEF.md
# Tagging Multi-Port Memory Arbiter

This block merges memory requests from several requesters onto one downstream memory port. Channel 0 belongs to a host command path. Channels 1 to N belong to processor cores. Each core has a private window of shared memory. The arbiter picks one pending request in round-robin order and forwards it with the winning channel's number appended as a tag.

A core request leaves the block with the core's region prefix placed above its local address bits, so each core can only reach its own slice of memory. A host request keeps its full-width address, so the host can reach every slice. Response routing is handled elsewhere, using the tag.

Control is a two-state machine:
- `ARB_SCAN`: looks at the pending requests.
  - It stays in `ARB_SCAN` while nothing is pending.
  - When at least one request is pending, it raises ready to the winner only, captures that request, and moves to `ARB_HOLD`.
- `ARB_HOLD`: presents the captured request on the output.
  - It stays in `ARB_HOLD` while the downstream ready is low.
  - It returns to `ARB_SCAN` on the cycle the downstream ready is high.

Each grant therefore costs one arbitration cycle plus the downstream stall. The downstream protocol allows stalls of any length.

Top module: `tag_mem_arbiter`

## Requirements
- R1: After reset, `m_valid` is low. With no request pending, all `req_ready` bits are low. The round-robin pointer starts so that channel 0 has first priority.
- R2: At most one `req_ready` bit is high at a time. It is high only for a channel whose `req_valid` is high, and only while `m_valid` is low.
- R3: `m_tag` equals the index of the channel whose request is being presented (0 for the host, k for core k).
- R4: A request from core k (k ≥ 1) is forwarded with address bits [LOCAL_AW-1:0] taken from the request. Bits [AW-1:LOCAL_AW] are set to k−1. The upper bits of the request's address are ignored.
- R5: A host request (channel 0) is forwarded with its full AW-bit address unchanged.
- R6: While `m_valid` is high and `m_ready` is low, all output fields (`m_tag`, `m_addr`, `m_wdata`, `m_we`) stay unchanged.
- R7: A new grant goes to the first channel with `req_valid` high, searching cyclically upward from the channel after the previous grant.
- R8: A request accepted at a clock edge is presented (`m_valid` high) from that edge on. After an output handshake, `m_valid` is low for exactly one cycle, the arbitration cycle.
- R9: `m_wdata` and `m_we` equal the accepted request's write data and write-enable bit.
- R10: Every accepted request appears at the output exactly once, and nothing appears that was not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCH | Per-channel request valid |
| req_ready | output | NCH | Per-channel accept, one-hot or zero |
| req_addr | input | NCH*AW | Per-channel address; channel k in slice k |
| req_wdata | input | NCH*DW | Per-channel write data |
| req_we | input | NCH | Per-channel write enable |
| m_valid | output | 1 | Downstream request valid |
| m_ready | input | 1 | Downstream ready; stalls of any length allowed |
| m_tag | output | TAGW | Winning channel number |
| m_addr | output | AW | Forwarded address (prefixed for cores) |
| m_wdata | output | DW | Forwarded write data |
| m_we | output | 1 | Forwarded write enable |

## Verification
Accepting a new request and holding or completing the current one compete for the same cycle. Every channel is kept pending while `m_ready` toggles at random. This provokes the case where `req_ready` could rise during a stall or right at a handshake.

The bench judges this against its own round-robin pointer. It requires `req_ready` to stay at zero whenever `m_valid` is high. It requires the next grant to go to the channel its model predicts. It also requires the one-cycle bubble after each handshake.

// File: rtl/mem_arb_pkg.sv
package mem_arb_pkg;
    typedef enum logic [0:0] {
        ARB_SCAN = 1'b0,
        ARB_HOLD = 1'b1
    } arb_state_e;
endpackage

// File: rtl/mem_arb_rr_pick.sv
// Round-robin search: first valid channel strictly after 'last', wrapping.
module mem_arb_rr_pick #(
    parameter int NCH = 4,
    parameter int IW  = $clog2(NCH)
) (
    input  logic [NCH-1:0] valid,
    input  logic [IW-1:0]  last,
    output logic           any,
    output logic [IW-1:0]  pick
);
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int i = 1; i <= NCH; i++) begin
            int idx;
            idx = int'(last) + i;
            if (idx >= NCH) idx = idx - NCH;
            if (!any && valid[idx]) begin
                any  = 1'b1;
                pick = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/mem_arb_remap.sv
// Per-channel address rewrite: host passes through, core k gets prefix k-1.
module mem_arb_remap #(
    parameter int NCH      = 4,
    parameter int AW       = 10,
    parameter int LOCAL_AW = 8
) (
    input  logic [NCH*AW-1:0] addr_in,
    output logic [NCH*AW-1:0] addr_out
);
    localparam int PFXW = AW - LOCAL_AW;

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        if (k == 0) begin : g_host
            assign addr_out[k*AW +: AW] = addr_in[k*AW +: AW];
        end else begin : g_core
            assign addr_out[k*AW +: AW] = {PFXW'(k - 1), addr_in[k*AW +: LOCAL_AW]};
        end
    end
endmodule

// File: rtl/tag_mem_arbiter.sv
module tag_mem_arbiter
    import mem_arb_pkg::*;
#(
    parameter  int N_CORES  = 3,
    parameter  int LOCAL_AW = 8,
    parameter  int DW       = 8,
    localparam int NCH      = N_CORES + 1,
    localparam int TAGW     = $clog2(NCH),
    localparam int PFXW     = (N_CORES > 1) ? $clog2(N_CORES) : 1,
    localparam int AW       = LOCAL_AW + PFXW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    req_valid,
    output logic [NCH-1:0]    req_ready,
    input  logic [NCH*AW-1:0] req_addr,
    input  logic [NCH*DW-1:0] req_wdata,
    input  logic [NCH-1:0]    req_we,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [TAGW-1:0]   m_tag,
    output logic [AW-1:0]     m_addr,
    output logic [DW-1:0]     m_wdata,
    output logic              m_we
);
    arb_state_e          state_q, state_d;
    logic [TAGW-1:0]     last_q;
    logic                any_req;
    logic [TAGW-1:0]     pick;
    logic [NCH*AW-1:0]   mapped_addr;
    logic [TAGW-1:0]     tag_q;
    logic [AW-1:0]       addr_q;
    logic [DW-1:0]       wdata_q;
    logic                we_q;
    logic                take;

    mem_arb_rr_pick #(.NCH(NCH), .IW(TAGW)) i_pick (
        .valid (req_valid),
        .last  (last_q),
        .any   (any_req),
        .pick  (pick)
    );

    mem_arb_remap #(.NCH(NCH), .AW(AW), .LOCAL_AW(LOCAL_AW)) i_remap (
        .addr_in  (req_addr),
        .addr_out (mapped_addr)
    );

    assign take = (state_q == ARB_SCAN) && any_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_SCAN: if (any_req) state_d = ARB_HOLD;
            ARB_HOLD: if (m_ready) state_d = ARB_SCAN;
            default:  state_d = ARB_SCAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_SCAN;
            last_q  <= TAGW'(NCH - 1);
        end else begin
            state_q <= state_d;
            if (take) last_q <= pick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
        end else if (take) begin
            tag_q   <= pick;
            addr_q  <= mapped_addr[int'(pick)*AW +: AW];
            wdata_q <= req_wdata[int'(pick)*DW +: DW];
            we_q    <= req_we[pick];
        end
    end

    always_comb begin
        req_ready = '0;
        m_valid   = 1'b0;
        unique case (state_q)
            ARB_SCAN: if (any_req) req_ready[pick] = 1'b1;
            ARB_HOLD: m_valid = 1'b1;
            default:  m_valid = 1'b0;
        endcase
    end

    assign m_tag   = tag_q;
    assign m_addr  = addr_q;
    assign m_wdata = wdata_q;
    assign m_we    = we_q;

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready) && ((req_ready & ~req_valid) == '0));
    // R2
    grant_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready != '0) |-> !m_valid);
    // R3
    tag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready != '0) |=> (m_tag == $past(pick)));
    // R5
    host_addr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready[0] |=> (m_addr == $past(req_addr[AW-1:0])));
    // R4
    core1_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready[1] |=> (m_addr == {PFXW'(0), $past(req_addr[AW +: LOCAL_AW])}));
    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_tag) && $stable(m_addr)
                                   && $stable(m_wdata) && $stable(m_we)));
    // R8
    present_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready != '0) |=> m_valid);
    // R8
    bubble_after_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready) |=> !m_valid);
endmodule

// File: tb/test_tag_mem_arbiter.sv
module test_tag_mem_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N_CORES  = 3;
    localparam int LOCAL_AW = 8;
    localparam int DW       = 8;
    localparam int NCH      = N_CORES + 1;
    localparam int TAGW     = $clog2(NCH);
    localparam int PFXW     = (N_CORES > 1) ? $clog2(N_CORES) : 1;
    localparam int AW       = LOCAL_AW + PFXW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    req_valid;
    logic [NCH-1:0]    req_ready;
    logic [NCH*AW-1:0] req_addr;
    logic [NCH*DW-1:0] req_wdata;
    logic [NCH-1:0]    req_we;
    logic              m_valid;
    logic              m_ready = 1'b0;
    logic [TAGW-1:0]   m_tag;
    logic [AW-1:0]     m_addr;
    logic [DW-1:0]     m_wdata;
    logic              m_we;

    logic [NCH-1:0] v  = '0;
    logic [AW-1:0]  a  [NCH];
    logic [DW-1:0]  d  [NCH];
    logic [NCH-1:0] we = '0;

    always_comb begin
        req_valid = v;
        req_we    = we;
        for (int k = 0; k < NCH; k++) begin
            req_addr[k*AW +: AW]  = a[k];
            req_wdata[k*DW +: DW] = d[k];
        end
    end

    tag_mem_arbiter #(.N_CORES(N_CORES), .LOCAL_AW(LOCAL_AW), .DW(DW)) i_tag_mem_arbiter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_we(req_we),
        .m_valid(m_valid), .m_ready(m_ready),
        .m_tag(m_tag), .m_addr(m_addr), .m_wdata(m_wdata), .m_we(m_we)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model state
    int             last_g = NCH - 1;
    bit             pend = 0;
    logic [TAGW-1:0] e_tag;
    logic [AW-1:0]  e_addr;
    logic [DW-1:0]  e_data;
    logic           e_we;
    int             n_acc = 0, n_del = 0;
    logic [NCH-1:0] acc_mask;
    bit             p_acc = 0, p_hs = 0, p_hold = 0;
    logic [TAGW-1:0] p_tag;
    logic [AW-1:0]  p_addr;
    logic [DW-1:0]  p_data;
    logic           p_we;

    function automatic logic [AW-1:0] exp_addr(int k, logic [AW-1:0] ad);
        if (k == 0) return ad;
        return {PFXW'(k - 1), ad[LOCAL_AW-1:0]};
    endfunction

    function automatic int rr_next(logic [NCH-1:0] vv, int last);
        for (int i = 1; i <= NCH; i++) begin
            int idx;
            idx = (last + i) % NCH;
            if (vv[idx]) return idx;
        end
        return -1;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic sample();
        int w;
        logic [NCH-1:0] em;
        acc_mask = '0;
        // R8: presented right after acceptance, bubble right after handshake
        if (p_acc) chk(m_valid == 1'b1, "R8 present", m_valid, 1);
        if (p_hs)  chk(m_valid == 1'b0, "R8 bubble", m_valid, 0);
        // R6: stalled output unchanged
        if (p_hold) chk({m_tag, m_addr, m_data_dummy(), m_we} == {p_tag, p_addr, p_data, p_we},
                        "R6 hold", {m_tag, m_addr, m_wdata}, {p_tag, p_addr, p_data});
        if (m_valid && m_ready) begin
            chk(pend, "R10 unexpected output", 1, pend);
            if (pend) begin
                chk(m_tag == e_tag, "R3 tag", m_tag, e_tag);
                chk(m_addr == e_addr, (e_tag == 0) ? "R5 host addr" : "R4 core addr", m_addr, e_addr);
                chk(m_wdata == e_data && m_we == e_we, "R9 data/we", {m_we, m_wdata}, {e_we, e_data});
                pend = 0;
                n_del++;
            end
        end
        // R2 / R7: grant prediction
        w  = rr_next(v, last_g);
        em = (m_valid || w < 0) ? '0 : (NCH'(1) << w);
        chk(req_ready == em, m_valid ? "R2 no grant while busy" : "R7 rr order", req_ready, em);
        if (req_ready != '0 && req_ready == em) begin
            chk(!pend, "R10 double accept", pend, 0);
            e_tag  = TAGW'(w);
            e_addr = exp_addr(w, a[w]);
            e_data = d[w];
            e_we   = we[w];
            pend   = 1;
            last_g = w;
            n_acc++;
            acc_mask = req_ready;
        end
        p_acc  = (req_ready != '0);
        p_hs   = m_valid && m_ready;
        p_hold = m_valid && !m_ready;
        p_tag = m_tag; p_addr = m_addr; p_data = m_wdata; p_we = m_we;
    endtask

    function automatic logic [DW-1:0] m_data_dummy();
        return m_wdata;
    endfunction

    // sample a quarter period after the negedge, then retire accepted valids
    task automatic step();
        #(CLK_PERIOD/4);
        sample();
        @(negedge clk);
        for (int k = 0; k < NCH; k++) if (acc_mask[k]) v[k] = 1'b0;
    endtask

    task automatic set_req(int k, logic [AW-1:0] ad, logic [DW-1:0] dt, logic w);
        v[k] = 1'b1; a[k] = ad; d[k] = dt; we[k] = w;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_del, n_acc);
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed_a11b);
        for (int k = 0; k < NCH; k++) begin a[k] = '0; d[k] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(m_valid == 1'b0 && req_ready == '0, "R1 in reset", {m_valid, req_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #(CLK_PERIOD/4);
        chk(m_valid == 1'b0 && req_ready == '0, "R1 after reset", {m_valid, req_ready}, 0);
        @(negedge clk);

        // Directed: all channels pending, long stall, cores with upper address bits set (R4/R5/R7)
        set_req(0, {AW{1'b1}}, 8'hA0, 1'b1);
        set_req(1, {AW{1'b1}}, 8'hA1, 1'b0);
        set_req(2, {{PFXW{1'b1}}, 8'h5C}, 8'hA2, 1'b1);
        set_req(3, {{PFXW{1'b0}}, 8'h33}, 8'hA3, 1'b0);
        m_ready = 1'b0;
        repeat (6) step();
        m_ready = 1'b1;
        repeat (16) step();

        // Directed: single core repeatedly, then host alone
        for (int r = 0; r < 3; r++) begin
            set_req(3, AW'(r * 37), DW'(r), r[0]);
            repeat (4) step();
        end
        set_req(0, {PFXW'(2), 8'hEE}, 8'h11, 1'b1);
        repeat (4) step();

        // Constrained random
        for (int c = 0; c < 4000; c++) begin
            for (int k = 0; k < NCH; k++)
                if (!v[k] && ($urandom % 4 == 0))
                    set_req(k, AW'($urandom), DW'($urandom), 1'($urandom));
            m_ready = ($urandom % 3) != 0;
            step();
        end

        // Drain
        m_ready = 1'b1;
        repeat (30) step();
        // R10: each accepted request delivered exactly once
        chk(n_acc == n_del && !pend && v == '0, "R10 count", n_del, n_acc);
        finish_run();
    end
endmodule